// File: doc/BRIEF.md
# Receive Packet Writer with Status Header

This block sits between the receive framing logic of an Ethernet MAC and the packet buffer. It takes one data word per cycle from a stream marked with first-word, last-word and CRC-good flags. It obtains a packet number from the buffer allocator and stores the payload at consecutive word offsets inside that packet. Each time the payload crosses into a new page, it asks the allocator for one more page. Word offsets 0 and 1 are left free while the frame is arriving. Once the last word has been stored, they are filled with a status word and the stored byte count.

A finished packet is placed in a small receive queue if its CRC was good, or if a policy input allows bad-CRC frames through. The receive interrupt stays high while the queue holds anything. Software reads the head packet number and then issues a remove-and-release command. That command pops the queue and hands the packet back to the allocator for freeing. A frame the block cannot finish is dropped and its packet freed. This happens when a page cannot be obtained, or when the queue is full at the end of the frame.

Top module: `rx_pkt_writer`

## Requirements
- R1: A frame is accepted only if `rx_enable` is high on its first word. A frame starting while it is low causes no allocation and no write.
- R2: The first word of an accepted frame raises `alloc_req` in that cycle. If `alloc_gnt` is low, the frame is discarded with no write, no release and no queue entry.
- R3: Payload words are written in the cycle they arrive. The first word goes to offset 2 of the granted packet, and each later word goes to the next offset.
- R4: Before the payload writes an offset that is a non-zero multiple of `PAGE_WORDS` (8), `ext_req` is raised in that cycle. If `ext_gnt` is low, this is an overrun: the word and the rest of the frame are discarded. The packet is released on `wr_free_*` in that cycle and gets no header and no queue entry.
- R5: In the cycle after the last word is stored, offset 0 receives the status word. In it, bit 0 = CRC error, bit 1 = too long, and the other bits are 0. The following cycle, offset 1 receives the byte count: 4 per stored word, and `s_nbytes` for a stored last word.
- R6: A packet with good CRC is pushed into the receive queue in the second cycle after its last word. It shows as `rx_fifo_head` when it reaches the front. `rx_irq` is high exactly while the queue is non-empty.
- R7: With `queue_bad_crc` = 0, a bad-CRC packet is released on `wr_free_*` and not queued. With `queue_bad_crc` = 1, it is queued like a good one.
- R8: `rx_pop` while the queue is non-empty raises `pop_free_valid` with the head packet number in that cycle, and the head advances at the next edge. `rx_pop` on an empty queue has no effect.
- R9: Words that would land at offset `PAGE_WORDS*MAX_PAGES` (32) or beyond are neither written nor counted, and status bit 1 is set.
- R10: A packet that would be queued while the queue holds `FIFO_DEPTH` entries is released on `wr_free_*` instead. The queue contents are unchanged.
- R11: A frame whose first word arrives while a header is being written is discarded entirely, including its later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable, sampled on a frame's first word |
| queue_bad_crc | input | 1 | Policy: also queue frames with bad CRC |
| s_valid | input | 1 | Stream word valid |
| s_sof | input | 1 | First word of frame |
| s_eof | input | 1 | Last word of frame |
| s_data | input | DATA_W | Stream word |
| s_nbytes | input | NB_W | Valid bytes in the last word |
| s_crc_ok | input | 1 | CRC good, sampled with the last word |
| alloc_req | output | 1 | Request a new packet |
| alloc_gnt | input | 1 | Allocation granted, same cycle |
| alloc_pkt | input | PKT_W | Granted packet number |
| ext_req | output | 1 | Request one more page for the current packet |
| ext_pkt | output | PKT_W | Packet being extended |
| ext_gnt | input | 1 | Page granted, same cycle |
| mem_we | output | 1 | Buffer write strobe |
| mem_pkt | output | PKT_W | Packet number of the write |
| mem_off | output | OFF_W | Word offset within the packet |
| mem_wdata | output | DATA_W | Write data |
| wr_free_valid | output | 1 | Writer releases a packet |
| wr_free_pkt | output | PKT_W | Packet released by the writer |
| rx_pop | input | 1 | Remove-and-release head of queue |
| rx_fifo_empty | output | 1 | Receive queue empty |
| rx_fifo_head | output | PKT_W | Packet number at queue head |
| pop_free_valid | output | 1 | Release of the popped packet |
| pop_free_pkt | output | PKT_W | Packet number being popped |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Writes, allocation and extension requests, drop releases and pop releases all appear in the same cycle as the input word or command that causes them. The bench therefore drives each input on the falling edge and checks these outputs shortly after, before the next rising edge. It also records every write in a bench-side model of the buffer. The header writes fall in the first and second cycles after the last word, and the queue push lands at the end of the second cycle. For that reason every frame task idles for several cycles before it inspects the header contents, `rx_fifo_head` or `rx_irq`. A pop is checked twice: its release output in the cycle of the command, and the new head on the falling edge after it.

// File: rtl/rx_pkt_writer.sv
module rx_pkt_writer #(
  parameter int DATA_W     = 32,
  parameter int PKT_W      = 4,
  parameter int PAGE_WORDS = 8,
  parameter int MAX_PAGES  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int BPW       = DATA_W / 8,
  localparam int NB_W      = $clog2(BPW + 1),
  localparam int MAX_WORDS = PAGE_WORDS * MAX_PAGES,
  localparam int OFF_W     = $clog2(MAX_WORDS),
  localparam int PG_W      = $clog2(PAGE_WORDS),
  localparam int CNT_W     = $clog2(MAX_WORDS * BPW + 1),
  localparam int FQ_W      = $clog2(FIFO_DEPTH),
  localparam int FC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              queue_bad_crc,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic [DATA_W-1:0] s_data,
  input  logic [NB_W-1:0]   s_nbytes,
  input  logic              s_crc_ok,
  output logic              alloc_req,
  input  logic              alloc_gnt,
  input  logic [PKT_W-1:0]  alloc_pkt,
  output logic              ext_req,
  output logic [PKT_W-1:0]  ext_pkt,
  input  logic              ext_gnt,
  output logic              mem_we,
  output logic [PKT_W-1:0]  mem_pkt,
  output logic [OFF_W-1:0]  mem_off,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr_free_valid,
  output logic [PKT_W-1:0]  wr_free_pkt,
  input  logic              rx_pop,
  output logic              rx_fifo_empty,
  output logic [PKT_W-1:0]  rx_fifo_head,
  output logic              pop_free_valid,
  output logic [PKT_W-1:0]  pop_free_pkt,
  output logic              rx_irq
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RECV = 3'd1, S_SKIP = 3'd2, S_HDR0 = 3'd3, S_HDR1 = 3'd4
  } st_t;

  localparam logic [OFF_W:0] OFF_LIMIT = (OFF_W+1)'(MAX_WORDS);

  st_t              st;
  logic [PKT_W-1:0] cur_pkt;
  logic [OFF_W:0]   off;
  logic [CNT_W-1:0] nbytes_acc;
  logic             too_long;
  logic             crc_err;

  logic [PKT_W-1:0] q_mem [FIFO_DEPTH];
  logic [FQ_W-1:0]  q_rd, q_wr;
  logic [FC_W-1:0]  fifo_cnt;

  logic             start, frame_word, room, ext_fail, wr_data, keep, fifo_full;
  logic             fifo_push, fifo_pop;
  logic [NB_W-1:0]  word_bytes;

  assign start      = (st == S_IDLE) && s_valid && s_sof && rx_enable;
  assign frame_word = (st == S_RECV) && s_valid;
  assign room       = off < OFF_LIMIT;
  assign ext_req    = frame_word && room && (off[PG_W-1:0] == '0);
  assign ext_pkt    = cur_pkt;
  assign ext_fail   = ext_req && !ext_gnt;
  assign wr_data    = frame_word && room && !ext_fail;
  assign word_bytes = s_eof ? s_nbytes : NB_W'(BPW);
  assign alloc_req  = start;

  assign mem_we  = (start && alloc_gnt) || wr_data || (st == S_HDR0) || (st == S_HDR1);
  assign mem_pkt = start ? alloc_pkt : cur_pkt;
  always_comb begin
    mem_off   = off[OFF_W-1:0];
    mem_wdata = s_data;
    if (st == S_HDR0) begin
      mem_off   = '0;
      mem_wdata = {{(DATA_W-2){1'b0}}, too_long, crc_err};
    end else if (st == S_HDR1) begin
      mem_off   = OFF_W'(1);
      mem_wdata = DATA_W'(nbytes_acc);
    end else if (start) begin
      mem_off   = OFF_W'(2);
    end
  end

  assign fifo_full     = fifo_cnt == FC_W'(FIFO_DEPTH);
  assign keep          = !crc_err || queue_bad_crc;
  assign fifo_push     = (st == S_HDR1) && keep && !fifo_full;
  assign wr_free_valid = ext_fail || ((st == S_HDR1) && !(keep && !fifo_full));
  assign wr_free_pkt   = cur_pkt;

  assign rx_fifo_empty  = fifo_cnt == '0;
  assign rx_irq         = !rx_fifo_empty;
  assign rx_fifo_head   = q_mem[q_rd];
  assign fifo_pop       = rx_pop && !rx_fifo_empty;
  assign pop_free_valid = fifo_pop;
  assign pop_free_pkt   = q_mem[q_rd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur_pkt    <= '0;
      off        <= '0;
      nbytes_acc <= '0;
      too_long   <= 1'b0;
      crc_err    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (s_valid && s_sof) begin
          if (start && alloc_gnt) begin
            cur_pkt    <= alloc_pkt;
            off        <= (OFF_W+1)'(3);
            nbytes_acc <= CNT_W'(word_bytes);
            too_long   <= 1'b0;
            crc_err    <= !s_crc_ok;
            st         <= s_eof ? S_HDR0 : S_RECV;
          end else begin
            st <= s_eof ? S_IDLE : S_SKIP;
          end
        end
        S_RECV: if (s_valid) begin
          if (ext_fail) begin
            st <= s_eof ? S_IDLE : S_SKIP;
          end else begin
            if (wr_data) begin
              off        <= off + 1'b1;
              nbytes_acc <= nbytes_acc + CNT_W'(word_bytes);
            end else begin
              too_long <= 1'b1;
            end
            if (s_eof) begin
              crc_err <= !s_crc_ok;
              st      <= S_HDR0;
            end
          end
        end
        S_SKIP: if (s_valid && s_eof) st <= S_IDLE;
        S_HDR0: st <= S_HDR1;
        S_HDR1: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_rd     <= '0;
      q_wr     <= '0;
      fifo_cnt <= '0;
    end else begin
      if (fifo_push) begin
        q_wr <= (q_wr == FQ_W'(FIFO_DEPTH-1)) ? '0 : q_wr + 1'b1;
      end
      if (fifo_pop) begin
        q_rd <= (q_rd == FQ_W'(FIFO_DEPTH-1)) ? '0 : q_rd + 1'b1;
      end
      fifo_cnt <= fifo_cnt + FC_W'(fifo_push) - FC_W'(fifo_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_push) q_mem[q_wr] <= cur_pkt;
  end

endmodule

// File: rtl/rx_pkt_writer_chk.sv
module rx_pkt_writer_chk #(
  parameter int OFF_W      = 5,
  parameter int FC_W       = 3,
  parameter int FIFO_DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic             alloc_req,
  input logic             mem_we,
  input logic [OFF_W-1:0] mem_off,
  input logic [2:0]       st,
  input logic [FC_W-1:0]  fifo_cnt,
  input logic             fifo_push,
  input logic             rx_pop,
  input logic             rx_fifo_empty,
  input logic             rx_irq
);

  p_disabled_no_alloc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !alloc_req);

  p_seq_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && mem_we && $past(mem_we) && $past(mem_off) >= OFF_W'(2))
      |-> mem_off == OFF_W'($past(mem_off) + 1'b1));

  p_hdr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> (mem_we && mem_off == OFF_W'(1)));

  p_irq_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(fifo_push));

  p_pop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_fifo_empty && !fifo_push) |=> fifo_cnt == FC_W'($past(fifo_cnt) - 1'b1));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == FC_W'(FIFO_DEPTH)) |-> !fifo_push);

endmodule

bind rx_pkt_writer rx_pkt_writer_chk #(
  .OFF_W(OFF_W), .FC_W(FC_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .alloc_req(alloc_req),
  .mem_we(mem_we), .mem_off(mem_off), .st(st), .fifo_cnt(fifo_cnt),
  .fifo_push(fifo_push), .rx_pop(rx_pop), .rx_fifo_empty(rx_fifo_empty),
  .rx_irq(rx_irq)
);

// File: tb/rx_pkt_writer_tb_top.sv
module rx_pkt_writer_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        rx_enable = 0, queue_bad_crc = 0;
  logic        s_valid = 0, s_sof = 0, s_eof = 0, s_crc_ok = 1;
  logic [31:0] s_data = '0;
  logic [2:0]  s_nbytes = '0;
  logic        alloc_req, ext_req, mem_we, wr_free_valid, rx_fifo_empty;
  logic        pop_free_valid, rx_irq, rx_pop = 0;
  logic        gnt_ok = 1, ext_ok = 1;
  logic [3:0]  next_pkt = '0;
  logic [3:0]  ext_pkt, mem_pkt, wr_free_pkt, rx_fifo_head, pop_free_pkt;
  logic [4:0]  mem_off;
  logic [31:0] mem_wdata;

  rx_pkt_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .queue_bad_crc(queue_bad_crc),
    .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof), .s_data(s_data),
    .s_nbytes(s_nbytes), .s_crc_ok(s_crc_ok),
    .alloc_req(alloc_req), .alloc_gnt(gnt_ok), .alloc_pkt(next_pkt),
    .ext_req(ext_req), .ext_pkt(ext_pkt), .ext_gnt(ext_ok),
    .mem_we(mem_we), .mem_pkt(mem_pkt), .mem_off(mem_off), .mem_wdata(mem_wdata),
    .wr_free_valid(wr_free_valid), .wr_free_pkt(wr_free_pkt),
    .rx_pop(rx_pop), .rx_fifo_empty(rx_fifo_empty), .rx_fifo_head(rx_fifo_head),
    .pop_free_valid(pop_free_valid), .pop_free_pkt(pop_free_pkt), .rx_irq(rx_irq)
  );

  logic [31:0] mm [16][32];
  int hdr_cnt [16];
  int wr_cnt = 0, alloc_cnt = 0, ext_cnt = 0, free_cnt = 0;
  logic [3:0] last_free = '0;
  int n_checks = 0, n_fail = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        mm[mem_pkt][mem_off] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (mem_off < 2) hdr_cnt[mem_pkt] <= hdr_cnt[mem_pkt] + 1;
      end
      if (alloc_req) alloc_cnt <= alloc_cnt + 1;
      if (ext_req) ext_cnt <= ext_cnt + 1;
      if (wr_free_valid) begin
        free_cnt <= free_cnt + 1;
        last_free <= wr_free_pkt;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_word(input logic sof, input logic eof, input logic [31:0] d,
                            input logic [2:0] nb, input logic crc);
    @(negedge clk);
    s_valid = 1; s_sof = sof; s_eof = eof; s_data = d; s_nbytes = nb; s_crc_ok = crc;
  endtask

  task automatic idle_in();
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] base, input logic [2:0] lastnb, input logic crc);
    for (int i = 0; i < n; i++)
      drive_word(i == 0, i == n - 1, base + i, (i == n - 1) ? lastnb : 3'd4, crc);
    idle_in();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic check_payload(input int pkt, input int n, input logic [31:0] base, input string tag);
    for (int i = 0; i < n && i < 30; i++)
      chk(mm[pkt][i+2] == base + i, tag, mm[pkt][i+2], base + i);
  endtask

  task automatic pop_expect(input logic [3:0] exp, input string tag);
    @(negedge clk);
    rx_pop = 1;
    #1;
    chk(pop_free_valid && pop_free_pkt == exp, tag, {27'd0, pop_free_valid, pop_free_pkt}, {28'd1, exp});
    @(negedge clk);
    rx_pop = 0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(rx_fifo_empty && !rx_irq && !mem_we && !alloc_req, "reset",
        {rx_fifo_empty, rx_irq, mem_we, alloc_req}, 4'b1000);
  endtask

  task automatic t_disabled();
    int a0 = alloc_cnt, w0 = wr_cnt;
    rx_enable = 0;
    send_frame(3, 32'h100, 3'd4, 1);
    chk(alloc_cnt == a0 && wr_cnt == w0, "R1 disabled frame ignored", wr_cnt - w0, 0);
    chk(rx_fifo_empty, "R1 queue empty", rx_fifo_empty, 1);
    rx_enable = 1;
  endtask

  task automatic t_basic();
    next_pkt = 4'd5;
    send_frame(4, 32'hA000, 3'd2, 1);
    check_payload(5, 4, 32'hA000, "R3 payload offsets");
    chk(mm[5][0] == 32'd0, "R5 status word", mm[5][0], 0);
    chk(mm[5][1] == 32'd14, "R5 byte count", mm[5][1], 14);
    chk(!rx_fifo_empty && rx_fifo_head == 4'd5 && rx_irq, "R6 queued and irq",
        {rx_irq, rx_fifo_head}, {1'b1, 4'd5});
  endtask

  task automatic t_extend();
    int e0 = ext_cnt;
    next_pkt = 4'd6;
    send_frame(10, 32'hB000, 3'd4, 1);
    chk(ext_cnt - e0 == 1, "R4 one page extension", ext_cnt - e0, 1);
    check_payload(6, 10, 32'hB000, "R4 payload across page");
    chk(mm[6][1] == 32'd40, "R5 byte count 10 words", mm[6][1], 40);
  endtask

  task automatic t_pop();
    pop_expect(4'd5, "R8 pop releases head");
    chk(rx_fifo_head == 4'd6, "R8 head advances", rx_fifo_head, 6);
    pop_expect(4'd6, "R8 pop second");
    chk(rx_fifo_empty && !rx_irq, "R6 irq drops when empty", rx_irq, 0);
    @(negedge clk); rx_pop = 1; #1;
    chk(!pop_free_valid, "R8 pop on empty ignored", pop_free_valid, 0);
    @(negedge clk); rx_pop = 0; #1;
    chk(rx_fifo_empty, "R8 still empty", rx_fifo_empty, 1);
  endtask

  task automatic t_badcrc();
    int f0 = free_cnt;
    queue_bad_crc = 0;
    next_pkt = 4'd7;
    send_frame(2, 32'hC000, 3'd3, 0);
    chk(mm[7][0] == 32'd1, "R5 crc error bit", mm[7][0], 1);
    chk(rx_fifo_empty && free_cnt - f0 == 1 && last_free == 4'd7, "R7 bad frame released",
        last_free, 7);
    queue_bad_crc = 1;
    next_pkt = 4'd8;
    send_frame(2, 32'hC100, 3'd3, 0);
    chk(!rx_fifo_empty && rx_fifo_head == 4'd8 && rx_irq, "R7 bad frame queued by policy",
        rx_fifo_head, 8);
    pop_expect(4'd8, "R8 pop bad frame");
    queue_bad_crc = 0;
  endtask

  task automatic t_ext_fail();
    int f0 = free_cnt;
    next_pkt = 4'd9;
    ext_ok = 0;
    send_frame(10, 32'hD000, 3'd4, 1);
    chk(free_cnt - f0 == 1 && last_free == 4'd9, "R4 overrun releases packet", last_free, 9);
    chk(hdr_cnt[9] == 0, "R4 overrun no header", hdr_cnt[9], 0);
    chk(rx_fifo_empty, "R4 overrun not queued", rx_fifo_empty, 1);
    ext_ok = 1;
  endtask

  task automatic t_alloc_fail();
    int w0 = wr_cnt, a0 = alloc_cnt, f0 = free_cnt;
    gnt_ok = 0;
    send_frame(3, 32'hE000, 3'd4, 1);
    chk(alloc_cnt - a0 == 1, "R2 allocation requested", alloc_cnt - a0, 1);
    chk(wr_cnt == w0 && free_cnt == f0 && rx_fifo_empty, "R2 denied frame discarded",
        wr_cnt - w0, 0);
    gnt_ok = 1;
  endtask

  task automatic t_too_long();
    int e0 = ext_cnt;
    next_pkt = 4'd10;
    send_frame(35, 32'hF000, 3'd4, 1);
    chk(mm[10][0] == 32'd2, "R9 too long status", mm[10][0], 2);
    chk(mm[10][1] == 32'd120, "R9 byte count truncated", mm[10][1], 120);
    chk(mm[10][31] == 32'hF000 + 29, "R9 last stored word", mm[10][31], 32'hF000 + 29);
    chk(ext_cnt - e0 == 3, "R4 three extensions", ext_cnt - e0, 3);
    pop_expect(4'd10, "R9 long frame queued");
  endtask

  task automatic t_single();
    next_pkt = 4'd2;
    send_frame(1, 32'h1234, 3'd1, 1);
    chk(mm[2][2] == 32'h1234 && mm[2][1] == 32'd1, "R3 single word frame", mm[2][1], 1);
    pop_expect(4'd2, "R6 single word queued");
  endtask

  task automatic t_sof_in_header();
    int a0 = alloc_cnt;
    next_pkt = 4'd3;
    drive_word(1, 0, 32'h300, 3'd4, 1);
    drive_word(0, 1, 32'h301, 3'd4, 1);
    drive_word(1, 0, 32'h400, 3'd4, 1);
    drive_word(0, 0, 32'h401, 3'd4, 1);
    drive_word(0, 1, 32'h402, 3'd4, 1);
    idle_in();
    repeat (3) @(negedge clk);
    #1;
    chk(alloc_cnt - a0 == 1, "R11 late frame not allocated", alloc_cnt - a0, 1);
    chk(mm[3][1] == 32'd8 && mm[3][2] == 32'h300 && mm[3][3] == 32'h301,
        "R11 first frame intact", mm[3][1], 8);
    pop_expect(4'd3, "R11 only first frame queued");
    chk(rx_fifo_empty, "R11 queue empty after", rx_fifo_empty, 1);
  endtask

  task automatic t_full();
    int f0;
    for (int p = 11; p < 15; p++) begin
      next_pkt = 4'(p);
      send_frame(2, 32'h5000 + p * 16, 3'd4, 1);
    end
    f0 = free_cnt;
    next_pkt = 4'd15;
    send_frame(2, 32'h6000, 3'd4, 1);
    chk(free_cnt - f0 == 1 && last_free == 4'd15, "R10 full queue releases", last_free, 15);
    for (int p = 11; p < 15; p++) begin
      chk(rx_fifo_head == 4'(p), "R10 queue contents unchanged", rx_fifo_head, p);
      pop_expect(4'(p), "R10 drain");
    end
    chk(rx_fifo_empty, "R10 drained", rx_fifo_empty, 1);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) hdr_cnt[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_disabled();
    t_basic();
    t_extend();
    t_pop();
    t_badcrc();
    t_ext_fail();
    t_alloc_fail();
    t_too_long();
    t_single();
    t_sof_in_header();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule